// File: doc/BRIEF.md
# Dual-Enable Byte-Lane Static RAM Model

This block is a synthesizable model of the pin behaviour of a 16-bit asynchronous static RAM. It lets a memory controller be checked without any external memory model. The pins are an address, a pair of chip enables of opposite polarity, a write strobe and an output strobe, all active low except the second enable, and one active-low strobe for each of the two byte lanes. The bidirectional data bus is split into a data input, a data output and a per-lane drive-enable pair. The array depth is set by the address width parameter.

The model samples every pin on a fast oversampling clock. A write window is open while both enables are active and the write strobe is low. The window ends when any one of those three signals goes inactive. At the first clock edge where the sampled window is closed, the address, data and lane strobes of the last sample inside the window are committed. Reads come straight out of the array, without a clock, for the current address. A sticky flag reports an address that moves while a write window is open.

Top module: `byte_lane_sram`

## Requirements
- R1: When `sel_n` is 1 or `sel` is 0, the part is deselected. Both bits of `dout_en` are 0 and no write takes place, whatever `wr_n`, `rd_n`, the lane strobes or the data are doing.
- R2: When the part is selected with `wr_n`=1 and `rd_n`=1, both bits of `dout_en` are 0.
- R3: When the part is selected with `wr_n`=1 and `rd_n`=0, `dout_en[0]` equals `!lo_n` and `dout_en[1]` equals `!hi_n`. In the same cycle, without waiting for a clock edge, each enabled lane of `dout` carries the stored lane for `addr`. The lower lane is `dout[7:0]` and the upper lane is `dout[15:8]`.
- R4: While the part is selected with `wr_n`=0, `rd_n` is ignored and both bits of `dout_en` are 0.
- R5: A committed write changes only the lanes whose strobe was 0: `lo_n` controls bits 7:0 and `hi_n` controls bits 15:8. The other lane keeps its old contents.
- R6: A write commits at the first clock edge where the sampled window is closed after it was open. Raising `wr_n`, raising `sel_n` or lowering `sel` each ends the window, and the new contents can be read right after that edge.
- R7: The committed address, data and lane strobes are those sampled at the last clock edge inside the window. Values applied together with the terminating change are not used.
- R8: With both lane strobes at 1, a selected read drives no lane and a write window changes no stored data.
- R9: `addr_err` is 0 after reset. It becomes 1 at a clock edge where the window is open in both this sample and the previous one and `addr` differs from the previous sample. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset of sampling state and error flag |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low chip enable |
| sel | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low output strobe |
| lo_n | input | 1 | Active-low strobe for bits 7:0 |
| hi_n | input | 1 | Active-low strobe for bits 15:8 |
| din | input | 2*LANE_W | Write data from the bus |
| dout | output | 2*LANE_W | Read data toward the bus |
| dout_en | output | 2 | Per-lane drive enable (bit 0 lower, bit 1 upper) |
| addr_err | output | 1 | Sticky flag: address moved inside a write window |

## Verification
The bench ends write windows in all three ways and changes the data, address and strobes on the terminating cycle. A design that latched the current sample instead of the previous one would then store the wrong word or the wrong lane. Each write holds the output strobe low for part of the window, so a model that lets `rd_n` drive the bus during a write shows up at once. Single-lane writes, writes with both strobes high and write attempts while deselected are each read back on both lanes, which catches a lane that is written when it should be left alone. The bench also moves the address inside an open window and checks that the flag is set, stays set and is cleared only by reset, and that the word lands at the last address inside the window.

// File: rtl/byte_lane_sram.sv
module byte_lane_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  sel_n,
  input  logic                  sel,
  input  logic                  wr_n,
  input  logic                  rd_n,
  input  logic                  lo_n,
  input  logic                  hi_n,
  input  logic [2*LANE_W-1:0]   din,
  output logic [2*LANE_W-1:0]   dout,
  output logic [1:0]            dout_en,
  output logic                  addr_err
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] s_addr;
  logic [WORD_W-1:0] s_din;
  logic              s_lo, s_hi, wa_q;

  wire picked = !sel_n && sel;
  wire wa_now = picked && !wr_n;
  wire rd_ok  = picked && wr_n && !rd_n;
  wire commit = wa_q && !wa_now;

  assign word    = mem[addr];
  assign dout_en = {rd_ok && !hi_n, rd_ok && !lo_n};
  assign dout    = {dout_en[1] ? word[WORD_W-1:LANE_W] : {LANE_W{1'b0}},
                    dout_en[0] ? word[LANE_W-1:0]      : {LANE_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q     <= 1'b0;
      s_addr   <= '0;
      s_din    <= '0;
      s_lo     <= 1'b1;
      s_hi     <= 1'b1;
      addr_err <= 1'b0;
    end else begin
      wa_q   <= wa_now;
      s_addr <= addr;
      s_din  <= din;
      s_lo   <= lo_n;
      s_hi   <= hi_n;
      if (wa_q && wa_now && addr != s_addr) addr_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (!s_lo) mem[s_addr][LANE_W-1:0]      <= s_din[LANE_W-1:0];
      if (!s_hi) mem[s_addr][WORD_W-1:LANE_W] <= s_din[WORD_W-1:LANE_W];
    end
  end

  assert_pd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |-> dout_en == 2'b00);

  assert_write_hides_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !wr_n) |-> dout_en == 2'b00);

  assert_lo_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !s_lo) |=> mem[$past(s_addr)][LANE_W-1:0] === $past(s_din[LANE_W-1:0]));

  assert_hi_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && s_hi) |=> mem[$past(s_addr)][WORD_W-1:LANE_W] === $past(mem[s_addr][WORD_W-1:LANE_W]));

  assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wa_q |=> mem[$past(s_addr)] === $past(mem[s_addr]));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);
endmodule

// File: tb/byte_lane_sram_test.sv
module byte_lane_sram_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
  logic [15:0] din = '0, dout;
  logic [1:0]  dout_en;
  logic        addr_err;
  logic [15:0] mirror [256];
  int          checks = 0, errors = 0;
  bit          done = 0;

  byte_lane_sram #(.ADDR_W(8), .LANE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel), .wr_n(wr_n),
    .rd_n(rd_n), .lo_n(lo_n), .hi_n(hi_n), .din(din), .dout(dout),
    .dout_en(dout_en), .addr_err(addr_err));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic l, logic h);
    return {h ? old[15:8] : d[15:8], l ? old[7:0] : d[7:0]};
  endfunction

  task automatic idle();
    @(negedge clk);
    sel_n = 1'b1; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d, logic l, logic h, int term);
    @(negedge clk);
    addr = a; din = d; lo_n = l; hi_n = h; sel_n = 1'b0; sel = 1'b1; wr_n = 1'b0;
    rd_n = 1'($urandom);
    #1 chk("R4 bus quiet in write", 32'(dout_en), 32'd0);
    @(negedge clk);
    rd_n = 1'b0;
    #1 chk("R4 rd_n ignored in write", 32'(dout_en), 32'd0);
    @(negedge clk);
    case (term)
      0: wr_n = 1'b1;
      1: sel_n = 1'b1;
      default: sel = 1'b0;
    endcase
    din = ~d; addr = 8'($urandom); lo_n = 1'($urandom); hi_n = 1'($urandom);
    mirror[a] = merge(mirror[a], d, l, h);
    idle();
  endtask

  task automatic do_read(logic [7:0] a, logic l, logic h, string req);
    @(negedge clk);
    addr = a; lo_n = l; hi_n = h; sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
    #1;
    chk({req, " lane enables"}, 32'(dout_en), 32'({!h, !l}));
    if (!l) chk({req, " low lane"}, 32'(dout[7:0]), 32'(mirror[a][7:0]));
    if (!h) chk({req, " high lane"}, 32'(dout[15:8]), 32'(mirror[a][15:8]));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset flag", 32'(addr_err), 32'd0);
    chk("R1 reset bus quiet", 32'(dout_en), 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) do_write(8'(a), 16'($urandom), 1'b0, 1'b0, a % 3);
    do_read(8'h10, 1'b0, 1'b0, "R3 read both");

    @(negedge clk);
    addr = 8'h10; sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b1; lo_n = 1'b0; hi_n = 1'b0;
    #1 chk("R2 output disabled", 32'(dout_en), 32'd0);
    @(negedge clk);
    sel_n = 1'b1; rd_n = 1'b0;
    #1 chk("R1 sel_n high", 32'(dout_en), 32'd0);
    @(negedge clk);
    sel_n = 1'b0; sel = 1'b0;
    #1 chk("R1 sel low", 32'(dout_en), 32'd0);
    @(negedge clk);
    sel_n = 1'b1; sel = 1'b1; wr_n = 1'b0; din = 16'hdead;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    idle();
    do_read(8'h10, 1'b0, 1'b0, "R1 no write deselected");

    do_write(8'h20, 16'hbeef, 1'b1, 1'b1, 0);
    do_read(8'h20, 1'b0, 1'b0, "R8 no lane written");
    do_read(8'h20, 1'b1, 1'b1, "R8 no lane driven");
    do_write(8'h21, 16'h1234, 1'b0, 1'b1, 1);
    do_read(8'h21, 1'b0, 1'b0, "R5 low only");
    do_write(8'h22, 16'h5678, 1'b1, 1'b0, 2);
    do_read(8'h22, 1'b0, 1'b0, "R5 high only");
    do_write(8'h23, 16'ha5a5, 1'b0, 1'b0, 0);
    do_read(8'h23, 1'b0, 1'b1, "R6 wr_n end");
    do_write(8'h24, 16'h5a5a, 1'b0, 1'b0, 1);
    do_read(8'h24, 1'b1, 1'b0, "R6 sel_n end");
    do_write(8'h25, 16'hc3c3, 1'b0, 1'b0, 2);
    do_read(8'h25, 1'b0, 1'b0, "R7 terminating sample unused");

    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(1, 0) == 1)
        do_write(8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(2, 0)));
      else
        do_read(8'($urandom), 1'($urandom), 1'($urandom), "R3 random read");
    end
    chk("R9 no error on clean traffic", 32'(addr_err), 32'd0);

    @(negedge clk);
    addr = 8'h30; din = 16'h0f0f; lo_n = 1'b0; hi_n = 1'b0; sel_n = 1'b0; sel = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    addr = 8'h31;
    @(negedge clk);
    wr_n = 1'b1;
    mirror[8'h31] = 16'h0f0f;
    #1 chk("R9 flag set", 32'(addr_err), 32'd1);
    idle();
    idle();
    #1 chk("R9 flag holds", 32'(addr_err), 32'd1);
    do_read(8'h31, 1'b0, 1'b0, "R7 last address in window");
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R9 reset clears flag", 32'(addr_err), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule